// File: doc/BRIEF.md
# Indirect Shared-Register Access Bridge

This block gives a host access to a bank of always-on shared registers through only two host-visible registers: a command word and a data word. The bridge runs entirely in the always-on domain. It has no wake request and no wake handshake, so the host can use it while the main processing domain is powered down.

To read a shared register, the host writes the command word with the target offset and the read opcode. The bridge runs one transfer on a simple internal register bus. When the shared-register side signals ready, the bridge captures the returned value into the data word, where the host reads it.

To write a shared register, the host stages the value in the data word first. It then writes the command word with the offset and the write opcode. The bridge then drives that staged value onto the internal bus.

While a transfer is outstanding, the command word reads back a busy flag. A second command that arrives during that time is discarded and raises a sticky error flag. The host clears that flag by writing 1 to it.

Top module: `shared_reg_bridge`

## Requirements
- R1: After reset, the command word (host offset 0xEC) and the data word (host offset 0xF4) both read 0, and neither internal bus enable is active.
- R2: While idle, a host write to the data word stores the value. It is readable at offset 0xF4 from the next cycle.
- R3: A command-word write while idle with opcode 2 in bits 29:28 and offset in bits 15:0 raises `shrRdEn` in the next cycle with `shrAddr` equal to that offset. The request holds with a stable address until `shrReady` is sampled high, and drops in the cycle after.
- R4: On the clock edge where `shrReady` is sampled high during a read, `shrRdData` is captured into the data word. The data word keeps that value until the next capture or accepted data write.
- R5: A command-word write while idle with opcode 3 raises `shrWrEn` in the next cycle, with `shrAddr` equal to the offset and `shrWrData` equal to the staged data word. All three hold stable until `shrReady` is sampled high.
- R6: Opcodes 0 and 1 start no bus transfer. They still update the offset (bits 15:0) and opcode (bits 29:28) fields read back from the command word.
- R7: Command-word bit 31 (busy) reads 1 from the cycle after a transfer starts through the cycle in which `shrReady` is high. A transfer with N wait cycles is therefore busy for N+1 cycles.
- R8: A command-word write while busy is discarded. This also applies in the cycle where `shrReady` is high. The discarded write leaves the offset, the opcode and the bus untouched, and sets the sticky error bit 30.
- R9: Bit 30 stays set until an idle command-word write carries 1 in bit 30, which clears it. In that same write, the opcode still takes effect.
- R10: A host write to the data word while busy is ignored. A pending write transfer keeps its original data.
- R11: Host offsets other than 0xEC and 0xF4 read as 0, and writes to them change nothing.
- R12: `shrRdEn` and `shrWrEn` are never active together, and only one transfer is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 12 | Host byte offset |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for `hostAddr`, combinational |
| shrAddr | output | 16 | Shared-register offset |
| shrWrData | output | 32 | Shared-register write data |
| shrWrEn | output | 1 | Shared-register write request |
| shrRdEn | output | 1 | Shared-register read request |
| shrRdData | input | 32 | Shared-register read data, valid with ready |
| shrReady | input | 1 | Transfer completes on the edge where this is high |

## Verification
Two events can fall in the same cycle: a transfer completing (`shrReady` high) and a new command-word write from the host. The bench provokes this with a bench-side shared-register model whose wait count is set to 2. It places the second command exactly in the ready cycle and first confirms at the ports that ready is high at that moment. The bench then judges the outcome. The first read's value must land in the data word. The second command's offset and opcode must not appear in the readback. The error bit must be set, and no further bus request may follow.

// File: rtl/shrb_pkg.sv
package shrb_pkg;
  localparam int BUSY_BIT = 31;
  localparam int ERR_BIT  = 30;
  localparam int OP_HI    = 29;
  localparam int OP_LO    = 28;

  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_WRITE = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bridgeState_e;

  typedef struct packed {
    logic latchCmd;
    logic clrErr;
    logic setErr;
    logic loadHost;
    logic loadRd;
  } bridgeStrobes_t;
endpackage

// File: rtl/shrb_ctrl.sv
module shrb_ctrl
  import shrb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter logic [HOST_AW-1:0] CTRL_OFF = 12'h0EC,
  parameter logic [HOST_AW-1:0] DATA_OFF = 12'h0F4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic [31:0]        hostWrData,
  input  logic               shrReady,
  output bridgeStrobes_t     strobes,
  output logic               busy,
  output logic               shrRdEn,
  output logic               shrWrEn
);
  bridgeState_e state, stateNext;
  logic ctrlWr, dataWr;
  logic [1:0] cmdOp;

  assign ctrlWr = hostWrEn && (hostAddr == CTRL_OFF);
  assign dataWr = hostWrEn && (hostAddr == DATA_OFF);
  assign cmdOp  = hostWrData[OP_HI:OP_LO];
  assign busy   = (state != ST_IDLE);
  assign shrRdEn = (state == ST_READ);
  assign shrWrEn = (state == ST_WRITE);

  always_comb begin
    strobes.latchCmd = ctrlWr && !busy;
    strobes.clrErr   = ctrlWr && !busy && hostWrData[ERR_BIT];
    strobes.setErr   = ctrlWr && busy;
    strobes.loadHost = dataWr && !busy;
    strobes.loadRd   = (state == ST_READ) && shrReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (strobes.latchCmd && cmdOp == OP_READ)       stateNext = ST_READ;
        else if (strobes.latchCmd && cmdOp == OP_WRITE) stateNext = ST_WRITE;
      end
      ST_READ, ST_WRITE: if (shrReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/shrb_datapath.sv
module shrb_datapath
  import shrb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter int OFF_W   = 16,
  parameter logic [HOST_AW-1:0] CTRL_OFF = 12'h0EC,
  parameter logic [HOST_AW-1:0] DATA_OFF = 12'h0F4
) (
  input  logic               clk,
  input  logic               rstN,
  input  bridgeStrobes_t     strobes,
  input  logic               busy,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWrData,
  input  logic [31:0]        shrRdData,
  output logic [31:0]        hostRdData,
  output logic [OFF_W-1:0]   shrAddr,
  output logic [31:0]        shrWrData
);
  localparam int PAD_W = OP_LO - OFF_W;

  logic [OFF_W-1:0] offsetReg;
  logic [1:0]       opReg;
  logic             errReg;
  logic [31:0]      dataReg;
  logic [31:0]      ctrlView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetReg <= '0;
      opReg     <= '0;
      errReg    <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (strobes.latchCmd) begin
        offsetReg <= hostWrData[OFF_W-1:0];
        opReg     <= hostWrData[OP_HI:OP_LO];
      end
      if (strobes.setErr)      errReg <= 1'b1;
      else if (strobes.clrErr) errReg <= 1'b0;
      if (strobes.loadRd)        dataReg <= shrRdData;
      else if (strobes.loadHost) dataReg <= hostWrData;
    end
  end

  assign ctrlView  = {busy, errReg, opReg, {PAD_W{1'b0}}, offsetReg};
  assign shrAddr   = offsetReg;
  assign shrWrData = dataReg;

  always_comb begin
    if (hostAddr == CTRL_OFF)      hostRdData = ctrlView;
    else if (hostAddr == DATA_OFF) hostRdData = dataReg;
    else                           hostRdData = '0;
  end
endmodule

// File: rtl/shared_reg_bridge.sv
module shared_reg_bridge
  import shrb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter int OFF_W   = 16,
  parameter logic [HOST_AW-1:0] CTRL_OFF = 12'h0EC,
  parameter logic [HOST_AW-1:0] DATA_OFF = 12'h0F4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic [31:0]        hostWrData,
  output logic [31:0]        hostRdData,
  output logic [OFF_W-1:0]   shrAddr,
  output logic [31:0]        shrWrData,
  output logic               shrWrEn,
  output logic               shrRdEn,
  input  logic [31:0]        shrRdData,
  input  logic               shrReady
);
  bridgeStrobes_t strobes;
  logic busy;

  shrb_ctrl #(.HOST_AW(HOST_AW), .CTRL_OFF(CTRL_OFF), .DATA_OFF(DATA_OFF)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .shrReady(shrReady), .strobes(strobes),
    .busy(busy), .shrRdEn(shrRdEn), .shrWrEn(shrWrEn)
  );

  shrb_datapath #(.HOST_AW(HOST_AW), .OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF),
                  .DATA_OFF(DATA_OFF)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .shrRdData(shrRdData),
    .hostRdData(hostRdData), .shrAddr(shrAddr), .shrWrData(shrWrData)
  );
endmodule

// File: rtl/shrb_checker.sv
module shrb_checker #(
  parameter int HOST_AW = 12,
  parameter int OFF_W   = 16,
  parameter logic [HOST_AW-1:0] CTRL_OFF = 12'h0EC
) (
  input logic               clk,
  input logic               rstN,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               hostWrEn,
  input logic [31:0]        hostWrData,
  input logic [OFF_W-1:0]   shrAddr,
  input logic [31:0]        shrWrData,
  input logic               shrWrEn,
  input logic               shrRdEn,
  input logic               shrReady,
  input logic               busy
);
  logic cmdWr;
  assign cmdWr = hostWrEn && (hostAddr == CTRL_OFF);

  a_r12_one_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shrRdEn, shrWrEn}));

  a_r3_read_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && hostWrData[29:28] == 2'd2)
      |=> (shrRdEn && shrAddr == $past(hostWrData[OFF_W-1:0])));

  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (shrRdEn && !shrReady) |=> (shrRdEn && $stable(shrAddr)));

  a_r5_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (shrWrEn && !shrReady) |=> (shrWrEn && $stable(shrAddr) && $stable(shrWrData)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    ((shrRdEn || shrWrEn) && shrReady) |=> !(shrRdEn || shrWrEn));

  a_r6_noop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && !hostWrData[29]) |=> !(shrRdEn || shrWrEn));

  a_r8_drop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy) |=> $stable(shrAddr));
endmodule

bind shared_reg_bridge shrb_checker #(
  .HOST_AW(HOST_AW), .OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF)
) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
  .hostWrData(hostWrData), .shrAddr(shrAddr), .shrWrData(shrWrData),
  .shrWrEn(shrWrEn), .shrRdEn(shrRdEn), .shrReady(shrReady), .busy(busy)
);

// File: tb/tb_shared_reg_bridge.sv
`timescale 1ns/1ps
module tb_shared_reg_bridge;
  localparam logic [11:0] CTRL = 12'h0EC;
  localparam logic [11:0] DATA = 12'h0F4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] hostAddr = '0;
  logic hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [15:0] shrAddr;
  logic [31:0] shrWrData;
  logic shrWrEn, shrRdEn;
  logic [31:0] shrRdData;
  logic shrReady;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [31:0] mem [16];
  int lat = 0;
  int cnt = 0;

  always #2.5 clk = ~clk;

  shared_reg_bridge dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .shrAddr(shrAddr),
    .shrWrData(shrWrData), .shrWrEn(shrWrEn), .shrRdEn(shrRdEn),
    .shrRdData(shrRdData), .shrReady(shrReady)
  );

  // Shared-register model with a programmable wait count
  assign shrReady  = (shrRdEn || shrWrEn) && (cnt == lat);
  assign shrRdData = mem[shrAddr[3:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      cnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 + i;
    end else if (shrRdEn || shrWrEn) begin
      if (shrReady) begin
        cnt <= 0;
        if (shrWrEn) mem[shrAddr[3:0]] <= shrWrData;
      end else cnt <= cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic clr, input logic [15:0] off);
    return {1'b0, clr, op, 12'h000, off};
  endfunction

  task automatic waitIdle(output int busyCount);
    logic [31:0] v;
    busyCount = 0;
    for (int k = 0; k < 40; k++) begin
      hostRead(CTRL, v);
      if (!v[31]) break;
      busyCount++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    int bc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    hostRead(CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
    hostRead(DATA, v); chk("R1 data after reset", v, 32'h0);
    chk("R1 bus idle after reset", {30'h0, shrRdEn, shrWrEn}, 32'h0);

    // R2 staging
    hostWrite(DATA, 32'hCAFE_0001);
    hostRead(DATA, v); chk("R2 staged data", v, 32'hCAFE_0001);

    // R11 other offsets
    hostWrite(12'h000, 32'hFFFF_FFFF);
    hostRead(12'h000, v); chk("R11 unmapped reads 0", v, 32'h0);
    hostRead(DATA, v); chk("R11 data untouched", v, 32'hCAFE_0001);
    hostRead(CTRL, v); chk("R11 ctrl untouched", v, 32'h0);

    // Sweep: every wait count 0..3, every register: write then read back
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int i = 0; i < 16; i++) begin
        pat = 32'hA500_0000 ^ (32'h0101_0101 * i) ^ (32'(l) << 20);
        hostWrite(DATA, pat);
        hostWrite(CTRL, cmd(2'd3, 1'b0, 16'(i)));
        hostRead(CTRL, v); chk("R5 write command shown busy", {31'h0, v[31]}, 32'h1);
        waitIdle(bc);
        chk("R7 busy length on write", 32'(bc), 32'(l + 1));
        chk("R5 shared register written", mem[i], pat);
        hostWrite(DATA, 32'h0);
        hostWrite(CTRL, cmd(2'd2, 1'b0, 16'(i)));
        waitIdle(bc);
        chk("R7 busy length on read", 32'(bc), 32'(l + 1));
        hostRead(DATA, v); chk("R4 read result", v, pat);
        hostRead(CTRL, v); chk("R3 ctrl readback offset/op", v, cmd(2'd2, 1'b0, 16'(i)));
      end
    end

    // R3/R8 collision: new command in the ready cycle
    lat = 2;
    hostWrite(CTRL, cmd(2'd2, 1'b0, 16'd5));
    @(negedge clk);
    @(negedge clk);
    chk("R8 ready high in collision cycle", {31'h0, shrReady}, 32'h1);
    hostWrite(CTRL, cmd(2'd3, 1'b0, 16'd9));
    chk("R8 no transfer after dropped command", {30'h0, shrRdEn, shrWrEn}, 32'h0);
    hostRead(CTRL, v); chk("R8 dropped command, error set", v, 32'h6000_0005);
    hostRead(DATA, v); chk("R4 read landed despite collision", v, mem[5]);

    // R6 no-op keeps error, updates fields, no transfer
    hostWrite(CTRL, cmd(2'd0, 1'b0, 16'd7));
    chk("R6 no-op 0 starts nothing", {30'h0, shrRdEn, shrWrEn}, 32'h0);
    hostRead(CTRL, v); chk("R9 error sticky", v, 32'h4000_0007);
    hostWrite(CTRL, cmd(2'd1, 1'b1, 16'd3));
    chk("R6 no-op 1 starts nothing", {30'h0, shrRdEn, shrWrEn}, 32'h0);
    hostRead(CTRL, v); chk("R9 error cleared by writing 1", v, 32'h1000_0003);

    // R10 data write during pending write is ignored
    lat = 3;
    hostWrite(DATA, 32'h1234_5678);
    hostWrite(CTRL, cmd(2'd3, 1'b0, 16'd2));
    hostWrite(DATA, 32'hDEAD_BEEF);
    chk("R10 bus data held", shrWrData, 32'h1234_5678);
    waitIdle(bc);
    chk("R10 shared register got original", mem[2], 32'h1234_5678);
    hostRead(DATA, v); chk("R10 data word unchanged", v, 32'h1234_5678);

    // R12 error bit also set when write dropped, and clear with active opcode
    hostWrite(CTRL, cmd(2'd2, 1'b0, 16'd4));
    hostWrite(CTRL, cmd(2'd2, 1'b0, 16'd6));
    chk("R12 single outstanding request", {30'h0, shrRdEn, shrWrEn}, 32'h2);
    waitIdle(bc);
    hostRead(DATA, v); chk("R12 only first read served", v, mem[4]);
    hostWrite(CTRL, cmd(2'd2, 1'b1, 16'd1));
    chk("R9 clear with read opcode starts read", {30'h0, shrRdEn, shrWrEn}, 32'h2);
    waitIdle(bc);
    hostRead(CTRL, v); chk("R9 error cleared, offset 1", v, 32'h2000_0001);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule